// File: doc/BRIEF.md
# Parallel-bus sequencer for a successive-approximation converter

This block sits on the host side of a 16-bit successive-approximation converter that is wired through its parallel data bus. On a start-of-run request it pulses the converter's reset line and waits for the initialization busy pulse to end. After that it issues conversion strobes, either one per request or periodically in a free-running mode. It follows the converter's busy flag through a two-flop synchronizer and opens the bus by pulling chip-select and read-enable low at the correct moment for the chosen read policy. It then returns each captured word on a valid/ready handshake.

Three read policies are supported. With read-after-convert, the word is fetched once busy has dropped, so the sample is the result of the conversion just finished. With read-during-convert, the word is fetched immediately after the next strobe, well inside the first half of the running conversion, so the sample is the result of the conversion before it. In continuous mode the bus is left enabled at all times and the word is taken when busy falls. The converter is assumed to emit straight binary. The host can ask for two's complement, in which case the top bit is inverted. The block flags a sample that overwrites an unaccepted one, and it raises a timeout if busy never falls after a reset or a strobe.

Top module: `adc_par_reader`

## Requirements
- R1: `adc_data` is captured only while `adc_cs_n` and `adc_rd_n` are both low. Outside continuous mode both lines stay high except during one read window, which is exactly RD_LOW_CLKS cycles long, and they are high after reset.
- R2: A `run_start` pulse in idle drives `adc_reset` high for exactly RST_CLKS consecutive cycles, with no conversion strobe during that time.
- R3: No `adc_cnv_start` is issued until `adc_busy` has been seen falling after `adc_reset` has returned low.
- R4: When `read_policy` is 0 or 3 (read after convert), the read window opens only after busy has fallen, and the delivered word is the result of the conversion just completed.
- R5: When `read_policy` is 1 (read during convert), the first conversion after initialization delivers nothing. Each later conversion delivers the previous conversion's result. The read window ends within HALF_CONV_CLKS cycles of the strobe.
- R6: When `read_policy` is 2 (continuous), `adc_cs_n` and `adc_rd_n` stay low. The word is captured on the synchronized falling edge of busy and is the result of that conversion.
- R7: With `want_twos` = 0 the captured word passes unchanged. With `want_twos` = 1 bit 15 (the top bit) is inverted and the other bits pass unchanged.
- R8: `smp_valid` stays high with `smp_data` unchanged until `smp_ready` is seen. It falls in the cycle after acceptance unless a new word arrives.
- R9: If a word is captured while `smp_valid` is high and `smp_ready` is low, `smp_overrun` pulses for one cycle and the new word replaces the old one.
- R10: Two successive conversion strobes are at least SAMPLE_CLKS cycles apart. Without `free_run`, each `run_start` given after initialization yields exactly one conversion. With `free_run` high, conversions repeat.
- R11: If busy does not fall within TIMEOUT_CLKS cycles after the reset pulse or after a strobe, `timeout_err` pulses once and the block returns to idle. It issues no further strobes until the next `run_start`.
- R12: `adc_cnv_start` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | From idle: start a run with initialization. Afterwards: request one conversion |
| free_run | input | 1 | Convert periodically while high |
| read_policy | input | 2 | 0/3 read after convert, 1 read during convert, 2 continuous; latched at run start |
| want_twos | input | 1 | 1: deliver two's complement, 0: straight binary |
| adc_reset | output | 1 | Reset line to the converter |
| adc_cnv_start | output | 1 | Conversion strobe, one cycle |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read enable, active low |
| adc_busy | input | 1 | Converter busy flag, asynchronous |
| adc_data | input | 16 | Converter parallel data bus |
| smp_valid | output | 1 | Captured sample available |
| smp_data | output | 16 | Captured sample in the chosen coding |
| smp_ready | input | 1 | Host accepts the sample |
| smp_overrun | output | 1 | One-cycle pulse: an unaccepted sample was overwritten |
| timeout_err | output | 1 | One-cycle pulse: busy did not fall in time |

## Verification
The assertions check the following on every cycle: a capture happens only with the bus enabled; no strobe comes before the initialization busy pulse has ended; the strobe is one cycle wide and strobes are spaced by at least one sample period; a post-conversion read never overlaps busy; a read during conversion stays inside the half-conversion window; and a pending sample is held. Only the bench scenarios can show that the delivered words match the right conversion for each policy, that the coding conversion is correct, that the first read-during-convert conversion produces no sample, that overrun reports occur, and that a silent converter leads to a timeout followed by no further activity.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    POL_AFTER  = 2'd0,
    POL_DURING = 2'd1,
    POL_CONT   = 2'd2
  } rd_pol_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_INIT,
    ST_READY,
    ST_START,
    ST_CONV,
    ST_READ
  } seq_st_e;

  // Map the raw policy code; the spare code behaves as read-after-convert.
  function automatic rd_pol_e decode_pol(input logic [1:0] code);
    case (code)
      2'd1:    decode_pol = POL_DURING;
      2'd2:    decode_pol = POL_CONT;
      default: decode_pol = POL_AFTER;
    endcase
  endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async,
  output logic busy_s,
  output logic busy_fall
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], busy_async};
  end

  assign busy_s    = sh[1];
  assign busy_fall = sh[2] & ~sh[1];

  // a fall is only reported on a level that was high one cycle before
  assert_fall_after_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_fall |-> $past(busy_s));
endmodule

// File: rtl/adc_sample_out.sv
module adc_sample_out #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_word,
  input  logic          want_twos,
  input  logic          smp_ready,
  output logic          smp_valid,
  output logic [DW-1:0] smp_data,
  output logic          smp_overrun
);
  // straight binary <-> two's complement differ only in the top bit
  function automatic logic [DW-1:0] recode(input logic [DW-1:0] w, input logic to_twos);
    logic [DW-1:0] r;
    r         = w;
    r[DW-1]   = w[DW-1] ^ to_twos;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid   <= 1'b0;
      smp_data    <= '0;
      smp_overrun <= 1'b0;
    end else begin
      smp_overrun <= cap_en & smp_valid & ~smp_ready;
      if (cap_en) begin
        smp_valid <= 1'b1;
        smp_data  <= recode(cap_word, want_twos);
      end else if (smp_ready) begin
        smp_valid <= 1'b0;
      end
    end
  end

  assert_hold_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && !cap_en) |=> (smp_valid && $stable(smp_data)));

  assert_overrun_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_overrun |-> $past(smp_valid));
endmodule

// File: rtl/adc_par_reader.sv
module adc_par_reader
  import adc_rd_pkg::*;
#(
  parameter int DW             = 16,
  parameter int SAMPLE_CLKS    = 188,
  parameter int RD_LOW_CLKS    = 2,
  parameter int HALF_CONV_CLKS = 60,
  parameter int RST_CLKS       = 4,
  parameter int TIMEOUT_CLKS   = 300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_start,
  input  logic          free_run,
  input  logic [1:0]    read_policy,
  input  logic          want_twos,
  output logic          adc_reset,
  output logic          adc_cnv_start,
  output logic          adc_cs_n,
  output logic          adc_rd_n,
  input  logic          adc_busy,
  input  logic [DW-1:0] adc_data,
  output logic          smp_valid,
  output logic [DW-1:0] smp_data,
  input  logic          smp_ready,
  output logic          smp_overrun,
  output logic          timeout_err
);
  localparam int CNT_TOP = ((SAMPLE_CLKS > TIMEOUT_CLKS) ? SAMPLE_CLKS : TIMEOUT_CLKS) + RST_CLKS + 2;
  localparam int CW      = $clog2(CNT_TOP) + 1;
  localparam int RCW     = $clog2(RD_LOW_CLKS) + 1;

  seq_st_e        st;
  rd_pol_e        pol_q;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  per_cnt;
  logic [RCW-1:0] rd_cnt;
  logic           rd_active, have_prev, req_q, tmo_q;

  // named internal events
  logic busy_s, busy_fall;
  logic rd_last, per_ok, tmo_hit, cap_en, want_conv;

  adc_busy_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_async(adc_busy),
    .busy_s    (busy_s),
    .busy_fall (busy_fall)
  );

  assign rd_last   = rd_active && (rd_cnt == RCW'(RD_LOW_CLKS - 1));
  assign per_ok    = per_cnt >= CW'(SAMPLE_CLKS - 1);
  assign tmo_hit   = (cnt == CW'(TIMEOUT_CLKS - 1)) && !busy_fall;
  assign want_conv = req_q || run_start || free_run;
  assign cap_en    = rd_last || ((st == ST_CONV) && (pol_q == POL_CONT) && busy_fall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pol_q     <= POL_AFTER;
      cnt       <= '0;
      per_cnt   <= '0;
      rd_cnt    <= '0;
      rd_active <= 1'b0;
      have_prev <= 1'b0;
      req_q     <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      tmo_q <= 1'b0;
      if (per_cnt != '1) per_cnt <= per_cnt + 1'b1;
      if (rd_active) begin
        rd_cnt <= rd_cnt + 1'b1;
        if (rd_last) rd_active <= 1'b0;
      end
      case (st)
        ST_IDLE: if (run_start) begin
          st        <= ST_RST;
          cnt       <= '0;
          pol_q     <= decode_pol(read_policy);
          have_prev <= 1'b0;
          req_q     <= 1'b0;
        end
        ST_RST: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(RST_CLKS - 1)) begin
            st  <= ST_INIT;
            cnt <= '0;
          end
        end
        ST_INIT: begin
          cnt <= cnt + 1'b1;
          if (busy_fall) begin
            st      <= ST_READY;
            per_cnt <= '1;
          end else if (tmo_hit) begin
            st    <= ST_IDLE;
            tmo_q <= 1'b1;
          end
        end
        ST_READY: begin
          if (run_start) req_q <= 1'b1;
          if (want_conv && per_ok) begin
            st    <= ST_START;
            req_q <= 1'b0;
          end
        end
        ST_START: begin
          st      <= ST_CONV;
          per_cnt <= '0;
          cnt     <= '0;
          if (pol_q == POL_DURING && have_prev) begin
            rd_active <= 1'b1;
            rd_cnt    <= '0;
          end
        end
        ST_CONV: begin
          cnt <= cnt + 1'b1;
          if (busy_fall) begin
            have_prev <= 1'b1;
            if (pol_q == POL_AFTER) begin
              st        <= ST_READ;
              rd_active <= 1'b1;
              rd_cnt    <= '0;
            end else begin
              st <= ST_READY;
            end
          end else if (tmo_hit) begin
            st        <= ST_IDLE;
            tmo_q     <= 1'b1;
            rd_active <= 1'b0;
          end
        end
        ST_READ: if (rd_last) st <= ST_READY;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign adc_reset     = (st == ST_RST);
  assign adc_cnv_start = (st == ST_START);
  assign adc_cs_n      = !((pol_q == POL_CONT) || rd_active);
  assign adc_rd_n      = !((pol_q == POL_CONT) || rd_active);
  assign timeout_err   = tmo_q;

  adc_sample_out #(.DW(DW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .cap_word   (adc_data),
    .want_twos  (want_twos),
    .smp_ready  (smp_ready),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .smp_overrun(smp_overrun)
  );

  // ---- observation state for the assertions ----
  logic [CW-1:0] conv_age;
  logic          conv_seen, init_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_age  <= '0;
      conv_seen <= 1'b0;
      init_seen <= 1'b0;
    end else begin
      if (adc_cnv_start) begin
        conv_age  <= CW'(1);
        conv_seen <= 1'b1;
      end else if (conv_age != '1) begin
        conv_age <= conv_age + 1'b1;
      end
      if (adc_reset)      init_seen <= 1'b0;
      else if (busy_fall) init_seen <= 1'b1;
    end
  end

  assert_capture_bus_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (!adc_cs_n && !adc_rd_n));

  assert_no_strobe_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_reset |-> !adc_cnv_start);

  assert_strobe_after_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnv_start |-> init_seen);

  assert_after_read_idle_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q == POL_AFTER && !adc_rd_n) |-> !busy_s);

  assert_during_read_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q == POL_DURING && !adc_rd_n) |-> (conv_age < CW'(HALF_CONV_CLKS)));

  assert_strobe_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_cnv_start && conv_seen) |-> (conv_age >= CW'(SAMPLE_CLKS)));

  assert_strobe_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnv_start |=> !adc_cnv_start);
endmodule

// File: tb/adc_par_reader_tb.sv
module adc_par_reader_tb;
  localparam int DW      = 16;
  localparam int SAMPLE  = 188;
  localparam int RDLOW   = 2;
  localparam int HALF    = 60;
  localparam int RSTC    = 4;
  localparam int TMO     = 300;
  localparam int CONV    = 120;
  localparam int INITB   = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0, run_start = 1'b0, free_run = 1'b0, want_twos = 1'b0, smp_ready = 1'b1;
  logic [1:0]    read_policy = 2'd0;
  logic          adc_reset, adc_cnv_start, adc_cs_n, adc_rd_n, adc_busy;
  logic [DW-1:0] adc_data, smp_data;
  logic          smp_valid, smp_overrun, timeout_err;

  adc_par_reader #(.DW(DW), .SAMPLE_CLKS(SAMPLE), .RD_LOW_CLKS(RDLOW), .HALF_CONV_CLKS(HALF),
                   .RST_CLKS(RSTC), .TIMEOUT_CLKS(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .free_run(free_run),
    .read_policy(read_policy), .want_twos(want_twos), .adc_reset(adc_reset),
    .adc_cnv_start(adc_cnv_start), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .adc_busy(adc_busy), .adc_data(adc_data), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .smp_overrun(smp_overrun), .timeout_err(timeout_err));

  // ---------------- converter model ----------------
  function automatic logic [15:0] code_of(input int k);
    return 16'(32'h1357 + 32'h4E21 * k);
  endfunction

  logic        m_en_init = 1'b1;
  int          m_cnt = 0;
  int          m_k = 0;
  logic        m_conv = 1'b0, m_rst_q = 1'b0;
  logic [15:0] m_out = 16'h0;

  always @(posedge clk) begin
    m_rst_q <= adc_reset;
    if (adc_reset) begin
      m_cnt <= 0;
      m_out <= 16'h0;
    end else if (m_rst_q && m_en_init) begin
      m_conv <= 1'b0;
      m_cnt  <= INITB;
    end else if (adc_cnv_start) begin
      m_conv <= 1'b1;
      m_cnt  <= CONV;
    end else if (m_cnt != 0) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1 && m_conv) begin
        m_out <= code_of(m_k);
        m_k   <= m_k + 1;
      end
    end
  end
  assign adc_busy = (m_cnt != 0);
  assign adc_data = (!adc_cs_n && !adc_rd_n) ? m_out : 16'hDEAD;

  // ---------------- monitors (sampled at falling edge) ----------------
  int n_chk = 0, n_err = 0;
  int cyc = 0, start_cnt = 0, last_start = 0, min_gap = 1000000, width_bad = 0, early_start = 0;
  int rd_run = 0, last_rd_run = 0, rst_run = 0, last_rst_run = 0, rst_starts = 0;
  int age = 0, max_rd_age = 0, n_smp = 0, ovr_cnt = 0, tmo_cnt = 0;
  logic [15:0] last_smp = 16'h0;
  logic prev_start = 1'b0, prev_busy = 1'b0, init_ok = 1'b0, done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    age++;
    if (adc_cnv_start) begin
      if (prev_start) width_bad++;
      else begin
        if (start_cnt > 0 && (cyc - last_start) < min_gap) min_gap = cyc - last_start;
        start_cnt++;
        last_start = cyc;
        age = 0;
      end
      if (!init_ok) early_start++;
    end
    prev_start = adc_cnv_start;
    if (adc_reset) init_ok = 1'b0;
    else if (prev_busy && !adc_busy) init_ok = 1'b1;
    prev_busy = adc_busy;
    if (!adc_rd_n) begin
      rd_run++;
      if (read_policy == 2'd1 && age > max_rd_age) max_rd_age = age;
    end else if (rd_run > 0) begin
      last_rd_run = rd_run;
      rd_run = 0;
    end
    if (adc_reset) begin
      if (adc_cnv_start) early_start++;
      rst_run++;
    end else if (rst_run > 0) begin
      last_rst_run = rst_run;
      rst_run = 0;
      rst_starts++;
    end
    if (smp_valid && smp_ready) begin
      n_smp++;
      last_smp = smp_data;
    end
    if (smp_overrun) ovr_cnt++;
    if (timeout_err) tmo_cnt++;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; free_run = 1'b0; run_start = 1'b0; smp_ready = 1'b1; want_twos = 1'b0;
    repeat (150) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_run();
    @(negedge clk) run_start = 1'b1;
    @(negedge clk) run_start = 1'b0;
  endtask

  task automatic wait_smp(input int maxc, output logic got, output logic [15:0] val);
    int n0 = n_smp;
    got = 1'b0;
    val = 16'h0;
    for (int i = 0; i < maxc && !got; i++) begin
      @(negedge clk);
      if (n_smp > n0) begin got = 1'b1; val = last_smp; end
    end
  endtask

  task automatic init_run(input logic [1:0] pol, input string tag);
    int s0 = start_cnt;
    int r0 = rst_starts;
    read_policy = pol;
    pulse_run();
    repeat (RSTC + INITB + 20) @(negedge clk);
    check({tag, " R2 reset pulse length"}, last_rst_run, RSTC);
    check({tag, " R2 one reset pulse"}, rst_starts - r0, 1);
    check({tag, " R2 no strobe during init"}, start_cnt - s0, 0);
  endtask

  task automatic shot(input int maxc, output logic got, output logic [15:0] val);
    pulse_run();
    wait_smp(maxc, got, val);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    do_reset();
    check("R1 cs_n high after reset", adc_cs_n, 1);
    check("R1 rd_n high after reset", adc_rd_n, 1);
    check("R2 reset line low in idle", adc_reset, 0);
    check("R12 no strobe in idle", adc_cnv_start, 0);
    check("R8 valid low after reset", smp_valid, 0);
    check("R11 no timeout after reset", timeout_err, 0);
  endtask

  task automatic t_after();
    logic got; logic [15:0] v; int k0; int s0;
    do_reset();
    init_run(2'd0, "after");
    for (int i = 0; i < 2; i++) begin
      k0 = m_k; s0 = start_cnt;
      shot(600, got, v);
      check("R4 sample delivered", got, 1);
      check("R4 current result", v, code_of(k0));
      check("R1 read window length", last_rd_run, RDLOW);
      repeat (200) @(negedge clk);
      check("R10 one conversion per request", start_cnt - s0, 1);
    end
    check("R3 no strobe before init end", early_start, 0);
  endtask

  task automatic t_coding();
    logic got; logic [15:0] v, c;
    want_twos = 1'b1;
    for (int i = 0; i < 2; i++) begin
      c = code_of(m_k);
      shot(600, got, v);
      check("R7 twos coding top bit", v, {~c[15], c[14:0]});
      repeat (200) @(negedge clk);
    end
    want_twos = 1'b0;
  endtask

  task automatic t_during();
    logic got; logic [15:0] v; int k1; int n0;
    do_reset();
    max_rd_age = 0;
    init_run(2'd1, "during");
    k1 = m_k; n0 = n_smp;
    pulse_run();
    repeat (400) @(negedge clk);
    check("R5 first conversion gives no sample", n_smp - n0, 0);
    shot(600, got, v);
    check("R5 sample delivered", got, 1);
    check("R5 previous result", v, code_of(k1));
    check("R5 read ends in first half", (max_rd_age > 0 && max_rd_age < HALF) ? 32'd1 : 32'd0, 1);
    check("R1 read window length during", last_rd_run, RDLOW);
    repeat (200) @(negedge clk);
  endtask

  task automatic t_cont();
    logic got; logic [15:0] v; int k0;
    do_reset();
    init_run(2'd2, "cont");
    check("R6 cs_n held low", adc_cs_n, 0);
    check("R6 rd_n held low", adc_rd_n, 0);
    k0 = m_k;
    shot(600, got, v);
    check("R6 result at busy fall", v, code_of(k0));
    check("R6 rd_n still low", adc_rd_n, 0);
    repeat (200) @(negedge clk);
  endtask

  task automatic t_free_overrun();
    int s0; int o0; logic [15:0] d0;
    do_reset();
    init_run(2'd0, "free");
    min_gap = 1000000;
    o0 = ovr_cnt;
    smp_ready = 1'b0;
    free_run = 1'b1;
    s0 = start_cnt;
    for (int i = 0; i < 3000 && (start_cnt - s0) < 4; i++) @(negedge clk);
    free_run = 1'b0;
    repeat (400) @(negedge clk);
    check("R10 free run repeats", ((start_cnt - s0) >= 4) ? 32'd1 : 32'd0, 1);
    check("R10 strobe spacing", (min_gap >= SAMPLE) ? 32'd1 : 32'd0, 1);
    check("R9 overrun reported", ((ovr_cnt - o0) >= 2) ? 32'd1 : 32'd0, 1);
    check("R8 valid held", smp_valid, 1);
    check("R9 newest word kept", smp_data, code_of(m_k - 1));
    d0 = smp_data;
    repeat (50) @(negedge clk);
    check("R8 data stable while pending", smp_data, d0);
    smp_ready = 1'b1;
    @(negedge clk);
    check("R8 valid drops after accept", smp_valid, 0);
  endtask

  task automatic t_timeout();
    int s0; int t0;
    do_reset();
    m_en_init = 1'b0;
    t0 = tmo_cnt;
    read_policy = 2'd0;
    pulse_run();
    repeat (RSTC + TMO + 20) @(negedge clk);
    check("R11 timeout pulse once", tmo_cnt - t0, 1);
    s0 = start_cnt;
    free_run = 1'b1;
    repeat (400) @(negedge clk);
    free_run = 1'b0;
    check("R11 no strobe after timeout", start_cnt - s0, 0);
    m_en_init = 1'b1;
  endtask

  initial begin
    t_reset_state();
    t_after();
    t_coding();
    t_during();
    t_cont();
    t_free_overrun();
    t_timeout();
    check("R12 strobe width one cycle", width_bad, 0);
    check("R3 strobe only after init", early_start, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule